// File: doc/BRIEF.md
# Conversion Result Readout Controller

This block sits between a converter's result path and a byte-wide serial port. It holds the newest 24-bit conversion result, drives an active-low data-ready flag, and hands the result to the host as three transmit bytes once the host asks for it. The serial shifter is outside the block: each completed byte slot is signalled by a one-cycle strobe carrying the byte the host sent in that slot, and the block presents the byte to send in the next slot.

Two ways of reading exist. A single-read command returns the current result once. A continuous-read command puts the block in a mode where every new result is sent out on its own, with no further command. In that mode the block keeps decoding every received byte, including the filler bytes the host clocks in while data is coming out. A stop byte or a reset byte seen while data-ready is low leaves the mode. Each readout begins with a programmable turnaround time, during which the transmit byte is held at zero. A result that arrives while a readout is in progress is held back. It is presented once that readout is over.

Top module: `rdo_readout_ctrl`

## Requirements
- R1: After reset, rdy_n is 1, tx_byte is 00h and cont_mode is 0.
- R2: When a readout starts, tx_byte stays 00h for DELAY clock cycles. On the DELAY-th rising edge after the start edge, it shows the first result byte.
- R3: A result is sent as bits 23:16, then bits 15:8, then bits 7:0. Each byte slot (xfer_stb with cs_n low) during a readout moves tx_byte to the next byte on the same edge.
- R4: On the edge that samples res_stb with no readout in progress, the result is stored and rdy_n goes to 0. The edge that completes the third byte slot sets rdy_n to 1 if nothing is pending.
- R5: A rising cs_n during a readout abandons it. tx_byte returns to 00h, rdy_n stays 0, and a later single read returns the same result again.
- R6: Byte 03h received outside continuous mode sets cont_mode. If rdy_n is 0, the current result is read out as well. In continuous mode, each new result starts a readout by itself.
- R7: In continuous mode while rdy_n is 0, a received 0Fh (stop) or FEh (reset) clears cont_mode on that edge, in any of the three byte slots. The readout in progress still completes.
- R8: In continuous mode while rdy_n is 1, received bytes leave cont_mode unchanged.
- R9: A result that arrives during a readout does not alter the bytes of that readout. It becomes the current result when the readout ends, and rdy_n then stays 0.
- R10: Byte 01h (single read) starts a readout only when rdy_n is 0 and the block is not in continuous mode. Otherwise tx_byte stays 00h.
- R11: Bytes received with cs_n high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select of the serial port |
| res_stb | input | 1 | One-cycle strobe: new conversion result |
| res_data | input | RES_W | Conversion result, valid with res_stb |
| xfer_stb | input | 1 | One-cycle strobe: a byte slot completed |
| rx_byte | input | 8 | Byte received from the host in that slot |
| tx_byte | output | 8 | Byte to send in the next slot |
| rdy_n | output | 1 | Active-low data-ready flag |
| cont_mode | output | 1 | Continuous read mode is active |

## Verification
A corrupt byte index shows at tx_byte within one byte slot, as a wrong or repeated byte. A wrong readout state shows up differently: either a non-zero byte during the turnaround, or a missing first byte exactly DELAY cycles after the command. A lost or mishandled pending result becomes visible at the end of the readout it overlapped, as rdy_n going high or a stale value on the next read. A faulty mode flag shows on the very next edge after a stop byte. It also shows at the next result, as a readout that starts without a command, or fails to.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SEND} rdo_state_e;

  localparam logic [7:0] CMD_READ_ONE  = 8'h01;
  localparam logic [7:0] CMD_READ_CONT = 8'h03;
  localparam logic [7:0] CMD_STOP      = 8'h0F;
  localparam logic [7:0] CMD_RESET     = 8'hFE;

  typedef struct packed {
    logic rd_one;
    logic rd_cont;
    logic quit;
  } rdo_cmd_t;
endpackage

// File: rtl/rdo_cmd_decode.sv
module rdo_cmd_decode
  import rdo_pkg::*;
(
  input  logic       valid_i,
  input  logic [7:0] byte_i,
  output rdo_cmd_t   cmd_o
);
  always_comb begin
    cmd_o.rd_one  = valid_i && (byte_i == CMD_READ_ONE);
    cmd_o.rd_cont = valid_i && (byte_i == CMD_READ_CONT);
    cmd_o.quit    = valid_i && ((byte_i == CMD_STOP) || (byte_i == CMD_RESET));
  end
endmodule

// File: rtl/rdo_lat_timer.sv
module rdo_lat_timer #(
  parameter int DELAY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic clr_i,
  output logic done_o,
  output logic run_o
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= CW'(DELAY);
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == CW'(1));
  assign run_o  = (cnt_q != '0);
endmodule

// File: rtl/rdo_result_buf.sv
module rdo_result_buf #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         busy_i,
  input  logic         release_i,
  output logic [W-1:0] cur_o,
  output logic         upd_o
);
  logic [W-1:0] cur_q;
  logic [W-1:0] pend_q;
  logic         pend_v_q;

  assign upd_o = release_i ? (load_i || pend_v_q) : (load_i && !busy_i);
  assign cur_o = cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (release_i) begin
      if (load_i)        cur_q <= data_i;
      else if (pend_v_q) cur_q <= pend_q;
      pend_v_q <= 1'b0;
    end else if (load_i) begin
      if (busy_i) begin
        pend_q   <= data_i;
        pend_v_q <= 1'b1;
      end else begin
        cur_q <= data_i;
      end
    end
  end
endmodule

// File: rtl/rdo_readout_ctrl.sv
module rdo_readout_ctrl
  import rdo_pkg::*;
#(
  parameter int RES_W = 24,
  parameter int DELAY = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             res_stb,
  input  logic [RES_W-1:0] res_data,
  input  logic             xfer_stb,
  input  logic [7:0]       rx_byte,
  output logic [7:0]       tx_byte,
  output logic             rdy_n,
  output logic             cont_mode
);
  localparam int BYTES = RES_W / 8;
  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  rdo_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       tx_q;
  logic             rdy_n_q, cont_q, cs_q;

  logic             xfer, busy, abort, done, release_rd;
  logic             upd, start, cmd_start, auto_start, quit, cont_d;
  logic             tmr_done, tmr_run;
  logic [RES_W-1:0] cur;
  rdo_cmd_t         cmd;

  function automatic logic [7:0] pick(input logic [RES_W-1:0] v, input logic [IDX_W-1:0] i);
    return 8'(v >> (8 * (BYTES - 1 - int'(i))));
  endfunction

  assign xfer       = xfer_stb && !cs_n;
  assign busy       = (state_q != ST_IDLE);
  assign abort      = busy && cs_n && !cs_q;
  assign done       = (state_q == ST_SEND) && xfer && (idx_q == IDX_W'(BYTES - 1));
  assign release_rd = done || abort;

  rdo_cmd_decode u_dec (
    .valid_i (xfer),
    .byte_i  (rx_byte),
    .cmd_o   (cmd)
  );

  rdo_result_buf #(.W(RES_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .load_i    (res_stb),
    .data_i    (res_data),
    .busy_i    (busy),
    .release_i (release_rd),
    .cur_o     (cur),
    .upd_o     (upd)
  );

  assign quit       = cont_q && !rdy_n_q && cmd.quit;
  assign cmd_start  = !busy && !cont_q && !rdy_n_q && (cmd.rd_one || cmd.rd_cont);
  assign auto_start = upd && cont_q && !quit;
  assign start      = cmd_start || auto_start;

  always_comb begin
    cont_d = cont_q;
    if (quit)                                 cont_d = 1'b0;
    else if (!busy && !cont_q && cmd.rd_cont) cont_d = 1'b1;
  end

  rdo_lat_timer #(.DELAY(DELAY)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .clr_i   (release_rd),
    .done_o  (tmr_done),
    .run_o   (tmr_run)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      tx_q    <= '0;
      rdy_n_q <= 1'b1;
      cont_q  <= 1'b0;
      cs_q    <= 1'b1;
    end else begin
      cs_q   <= cs_n;
      cont_q <= cont_d;
      if (upd)       rdy_n_q <= 1'b0;
      else if (done) rdy_n_q <= 1'b1;

      if (start) begin
        state_q <= ST_WAIT;
        idx_q   <= '0;
        tx_q    <= '0;
      end else if (release_rd) begin
        state_q <= ST_IDLE;
        idx_q   <= '0;
        tx_q    <= '0;
      end else if (state_q == ST_WAIT && tmr_done) begin
        state_q <= ST_SEND;
        idx_q   <= '0;
        tx_q    <= pick(cur, '0);
      end else if (state_q == ST_SEND && xfer) begin
        idx_q <= IDX_W'(idx_q + 1'b1);
        tx_q  <= pick(cur, IDX_W'(idx_q + 1'b1));
      end
    end
  end

  assign tx_byte   = tx_q;
  assign rdy_n     = rdy_n_q;
  assign cont_mode = cont_q;
endmodule

// File: rtl/rdo_readout_chk.sv
module rdo_readout_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       res_stb,
  input logic       xfer_stb,
  input logic [7:0] rx_byte,
  input logic [7:0] tx_byte,
  input logic       rdy_n,
  input logic       cont_mode,
  input logic       busy,
  input logic       tmr_run
);
  a_r2_quiet_in_delay: assert property (@(posedge clk) disable iff (rst)
    tmr_run |-> tx_byte == 8'h00);

  a_r4_ready_on_result: assert property (@(posedge clk) disable iff (rst)
    (res_stb && !busy) |=> !rdy_n);

  a_r4_ready_after_slot: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_n) |-> $past(xfer_stb && !cs_n));

  a_r5_abort_quiet: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> tx_byte == 8'h00);

  a_r7_quit_exits: assert property (@(posedge clk) disable iff (rst)
    (cont_mode && !rdy_n && xfer_stb && !cs_n && (rx_byte == 8'h0F || rx_byte == 8'hFE))
      |=> !cont_mode);

  a_r8_mode_kept: assert property (@(posedge clk) disable iff (rst)
    (cont_mode && rdy_n) |=> cont_mode);

  a_r10_no_stale_read: assert property (@(posedge clk) disable iff (rst)
    (!cont_mode && rdy_n && !busy) |=> tx_byte == 8'h00);

  a_r11_deselected_idle: assert property (@(posedge clk) disable iff (rst)
    (cs_n && !busy) |=> tx_byte == 8'h00);
endmodule

bind rdo_readout_ctrl rdo_readout_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .res_stb   (res_stb),
  .xfer_stb  (xfer_stb),
  .rx_byte   (rx_byte),
  .tx_byte   (tx_byte),
  .rdy_n     (rdy_n),
  .cont_mode (cont_mode),
  .busy      (busy),
  .tmr_run   (tmr_run)
);

// File: tb/rdo_readout_ctrl_tb.sv
module rdo_readout_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int DLY   = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        res_stb = 1'b0;
  logic [23:0] res_data = '0;
  logic        xfer_stb = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic [7:0]  tx_byte;
  logic        rdy_n, cont_mode;

  int errors = 0;
  int checks = 0;

  always #(CLK_P / 2) clk = ~clk;

  rdo_readout_ctrl #(.RES_W(24), .DELAY(DLY)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .res_stb(res_stb), .res_data(res_data),
    .xfer_stb(xfer_stb), .rx_byte(rx_byte), .tx_byte(tx_byte),
    .rdy_n(rdy_n), .cont_mode(cont_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b);
    @(negedge clk); rx_byte = b; xfer_stb = 1'b1;
    @(negedge clk); xfer_stb = 1'b0; rx_byte = '0;
  endtask

  task automatic load(input logic [23:0] d);
    @(negedge clk); res_data = d; res_stb = 1'b1;
    @(negedge clk); res_stb = 1'b0;
  endtask

  task automatic read3(input logic [23:0] d, input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2, input int quit_slot, input string tag);
    for (int i = 1; i < DLY; i++) begin
      @(negedge clk); chk({tag, " R2 zero during delay"}, tx_byte, 0);
    end
    @(negedge clk); chk({tag, " R2 R3 first byte"}, tx_byte, d[23:16]);
    xfer(b0);
    if (quit_slot == 0) chk({tag, " R7 quit slot 0"}, cont_mode, 0);
    chk({tag, " R3 middle byte"}, tx_byte, d[15:8]);
    xfer(b1);
    if (quit_slot == 1) chk({tag, " R7 quit slot 1"}, cont_mode, 0);
    chk({tag, " R3 last byte"}, tx_byte, d[7:0]);
    xfer(b2);
    if (quit_slot == 2) chk({tag, " R7 quit slot 2"}, cont_mode, 0);
  endtask

  task automatic t_reset();
    chk("R1 rdy_n", rdy_n, 1);
    chk("R1 tx", tx_byte, 0);
    chk("R1 cont", cont_mode, 0);
  endtask

  task automatic t_single();
    @(negedge clk); cs_n = 1'b0;
    load(24'hA5B6C7);
    chk("R4 rdy_n low on result", rdy_n, 0);
    xfer(8'h01);
    read3(24'hA5B6C7, 8'h00, 8'h00, 8'h00, 3, "single");
    chk("R4 rdy_n high after 24 bits", rdy_n, 1);
    chk("R3 tx idle after read", tx_byte, 0);
  endtask

  task automatic t_read_without_data();
    xfer(8'h01);
    repeat (DLY + 2) @(negedge clk);
    chk("R10 no readout when rdy_n high", tx_byte, 0);
  endtask

  task automatic t_partial();
    load(24'h112233);
    xfer(8'h01);
    repeat (DLY) @(negedge clk);
    chk("R5 first byte before abort", tx_byte, 8'h11);
    cs_n = 1'b1;
    @(negedge clk);
    chk("R5 tx zero after abort", tx_byte, 0);
    chk("R5 rdy_n stays low", rdy_n, 0);
    cs_n = 1'b0;
    xfer(8'h01);
    read3(24'h112233, 8'h00, 8'h00, 8'h00, 3, "reread R5");
    chk("R5 rdy_n high after full read", rdy_n, 1);
  endtask

  task automatic t_deselected();
    cs_n = 1'b1;
    load(24'h445566);
    xfer(8'h01);
    repeat (DLY + 2) @(negedge clk);
    chk("R11 command ignored with cs_n high", tx_byte, 0);
    chk("R11 rdy_n still low", rdy_n, 0);
    cs_n = 1'b0;
  endtask

  task automatic t_continuous();
    xfer(8'h03);
    chk("R6 cont set", cont_mode, 1);
    read3(24'h445566, 8'h00, 8'h00, 8'h00, 3, "R6 enter");
    chk("R4 rdy_n high", rdy_n, 1);
    xfer(8'h0F);
    chk("R8 stop ignored while rdy_n high", cont_mode, 1);
    load(24'h778899);
    read3(24'h778899, 8'h00, 8'h00, 8'h00, 3, "R6 auto");
    chk("R6 cont still set", cont_mode, 1);
    load(24'hABCDEF);
    read3(24'hABCDEF, 8'h00, 8'h0F, 8'h00, 1, "stop");
    xfer(8'h03);
    chk("R6 re-enter without data", cont_mode, 1);
    load(24'h123456);
    read3(24'h123456, 8'h00, 8'h00, 8'hFE, 2, "reset byte");
    xfer(8'h03);
    load(24'h654321);
    read3(24'h654321, 8'h0F, 8'h00, 8'h00, 0, "stop first");
    load(24'h010203);
    repeat (DLY + 2) @(negedge clk);
    chk("R7 no auto readout after quit", tx_byte, 0);
    xfer(8'h01);
    read3(24'h010203, 8'h00, 8'h00, 8'h00, 3, "after quit");
  endtask

  task automatic t_buffered();
    load(24'hC0FFEE);
    xfer(8'h01);
    repeat (DLY) @(negedge clk);
    chk("R9 first byte", tx_byte, 8'hC0);
    load(24'h0BADF0);
    chk("R9 tx unchanged by new result", tx_byte, 8'hC0);
    xfer(8'h00); chk("R9 middle byte of old", tx_byte, 8'hFF);
    xfer(8'h00); chk("R9 last byte of old", tx_byte, 8'hEE);
    xfer(8'h00);
    chk("R9 rdy_n low for buffered", rdy_n, 0);
    xfer(8'h01);
    read3(24'h0BADF0, 8'h00, 8'h00, 8'h00, 3, "R9 buffered");
    chk("R9 rdy_n high at end", rdy_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_read_without_data();
    t_partial();
    t_deselected();
    t_continuous();
    t_buffered();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule